// File: doc/BRIEF.md
# Clock-Stop SPI Master

This block moves one word at a time over a four-wire serial link as the link master. A host presents a parallel transmit word together with a one-cycle start pulse while `ready_o` is high. The block then drives the active-low select low and puts the most significant transmit bit on the data output. After one low half-period it produces exactly `WORD_W` clock pulses. Each later transmit bit appears on a rising clock edge, and each receive bit is taken on a falling clock edge. The serial clock stays low whenever no word is in flight.

The pace of the link is set outside the block. `tick_i` marks each half-period boundary, so any divider or rate source can drive the block. When the final falling edge occurs, select returns high and the data-output drive enable drops in the same cycle, which lets the pad float. The assembled receive word is then shown with a single-cycle valid pulse. The block is ready for the next word in that same cycle, so transfers can follow one another directly.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, and at all times while no word is in flight, `sclk_o` is 0, `ss_no` is 1, `mosi_oe_o` is 0 and `ready_o` is 1. Ticks that arrive while the block is idle cause no clock edge.
- R2: A start pulse taken while `ready_o` is 1 drives `ss_no` low on the next clock edge. The first rising edge of `sclk_o` comes on the first tick after that, so select leads the clock by one low half-period.
- R3: Each word has exactly `WORD_W` rising edges of `sclk_o`. Every edge of `sclk_o` happens only on a cycle where `tick_i` is 1, and high and low half-periods alternate.
- R4: `mosi_o` carries transmit bit `WORD_W-1` from the cycle select goes low. After that it changes only together with a rising edge of `sclk_o`, one bit per edge, ending with bit 0.
- R5: `miso_i` is sampled on each falling-edge tick. The first sampled bit becomes bit `WORD_W-1` of `rx_word_o` and the last one becomes bit 0.
- R6: `ss_no` returns to 1 and `mosi_oe_o` to 0 on the same clock edge as the final falling edge of `sclk_o`.
- R7: `rx_valid_o` is high for exactly one cycle, and that cycle is the first one in which `ss_no` is back at 1. `rx_word_o` keeps its value until the next word completes.
- R8: A start pulse given while a word is in flight is ignored. The word in flight is unchanged, and no further word follows it.
- R9: `ready_o` is 1 in the cycle `rx_valid_o` pulses. A start given in that cycle begins a new word at once, and the new word is transferred correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-period boundary strobe |
| start_i | input | 1 | Begin a word (taken when ready) |
| tx_word_i | input | WORD_W | Word to transmit, captured with start |
| ready_o | output | 1 | Idle and able to take a start |
| rx_word_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_word_o |
| sclk_o | output | 1 | Serial clock, idles low |
| ss_no | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Drive enable for the data-out pad |
| miso_i | input | 1 | Serial data in |

## Verification
The end of one word and the acceptance of the next can fall in the same cycle. The receive-valid pulse, the return of select and a fresh start pulse all meet on one clock edge. To provoke this, the bench raises start in exactly the cycle it sees the valid strobe. It then checks three things: the first word's receive value holds while the second word is in flight, select falls again on the next edge, and the second word's transmit and receive bits arrive intact and in order. Runs at several tick spacings, including a tick on every cycle, also make the final falling edge and the start of a new word meet at the shortest spacing.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } spi_st_e;
endpackage

// File: rtl/spi_cs_seq.sv
module spi_cs_seq import spi_cs_pkg::*; #(
  parameter int WORD_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic ready_o,
  output logic load_o,
  output logic shift_o,
  output logic sample_o,
  output logic last_o,
  output logic sclk_o,
  output logic ss_no,
  output logic oe_o
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WORD_W - 1);

  spi_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign load_o   = ready_o & start_i;
  assign shift_o  = tick_i & (state_q == ST_LOW);
  assign sample_o = tick_i & (state_q == ST_HIGH);
  assign last_o   = sample_o & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sclk_o  <= 1'b0;
      ss_no   <= 1'b1;
      oe_o    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_LEAD;
          cnt_q   <= CNT_TOP;
          ss_no   <= 1'b0;
          oe_o    <= 1'b1;
        end
        ST_LEAD, ST_LOW: if (tick_i) begin
          state_q <= ST_HIGH;
          sclk_o  <= 1'b1;
        end
        ST_HIGH: if (tick_i) begin
          sclk_o <= 1'b0;
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            ss_no   <= 1'b1;
            oe_o    <= 1'b0;
          end else begin
            state_q <= ST_LOW;
            cnt_q   <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  logic [WORD_W-1:0] tx_sr_q;
  logic [WORD_W-1:0] rx_sr_q;
  logic [WORD_W-1:0] rx_next;

  assign rx_next = {rx_sr_q[WORD_W-2:0], miso_i};
  assign mosi_o  = tx_sr_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
    end else if (load_i) begin
      tx_sr_q <= tx_word_i;
    end else if (shift_i) begin
      tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q    <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= last_i;
      if (sample_i) rx_sr_q <= rx_next;
      if (last_i)   rx_word_o <= rx_next;
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              ss_no,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);
  logic load, shift, sample, last;

  spi_cs_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (start_i),
    .ready_o  (ready_o),
    .load_o   (load),
    .shift_o  (shift),
    .sample_o (sample),
    .last_o   (last),
    .sclk_o   (sclk_o),
    .ss_no    (ss_no),
    .oe_o     (mosi_oe_o)
  );

  spi_cs_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .shift_i    (shift),
    .sample_i   (sample),
    .last_i     (last),
    .tx_word_i  (tx_word_i),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o)
  );
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic ready_o,
  input logic rx_valid_o,
  input logic sclk_o,
  input logic ss_no,
  input logic mosi_o,
  input logic mosi_oe_o
);
  p_idle_clk_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o);
  p_lead_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_no) |-> (!sclk_o && $past(ready_o && start_i)));
  p_rise_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(!ss_no));
  p_edge_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(tick_i));
  p_mosi_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_no && $past(!ss_no) && !$rose(sclk_o)) |-> $stable(mosi_o));
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_no) |-> (!mosi_oe_o && $fell(sclk_o)));
  p_oe_in_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> !ss_no);
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  p_valid_at_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($rose(ss_no) && ready_o));
  p_busy_no_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_no |-> !ready_o);
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .start_i    (start_i),
  .ready_o    (ready_o),
  .rx_valid_o (rx_valid_o),
  .sclk_o     (sclk_o),
  .ss_no      (ss_no),
  .mosi_o     (mosi_o),
  .mosi_oe_o  (mosi_oe_o)
);

// File: tb/spi_cs_master_bench.sv
`timescale 1ns/1ps
module spi_cs_master_bench;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] tx_word_i = '0;
  logic         ready_o, rx_valid_o, sclk_o, ss_no, mosi_o, mosi_oe_o;
  logic [W-1:0] rx_word_o;
  logic         miso_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int tick_div = 3;
  int tcnt = 0;

  logic [W-1:0] slv_word = '0;
  logic [W-1:0] slv_sr = '0;
  logic [W-1:0] mon_word = '0;
  int rises = 0;
  int lead = 0;
  bit in_lead = 0;
  int idle_edges = 0;
  logic prev_ss = 1'b1;
  logic prev_sclk = 1'b0;

  spi_cs_master #(.WORD_W(W)) u_spi_cs_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .tx_word_i(tx_word_i), .ready_o(ready_o), .rx_word_o(rx_word_o),
    .rx_valid_o(rx_valid_o), .sclk_o(sclk_o), .ss_no(ss_no),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
  );

  always #4 clk_i = ~clk_i;

  // tick source
  initial forever begin
    @(negedge clk_i);
    tcnt   = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    tick_i = (tcnt == tick_div - 1);
  end

  // slave model and link monitor
  initial forever begin
    @(negedge clk_i);
    if (ss_no && prev_ss && sclk_o) idle_edges++;
    if (!ss_no && prev_ss) begin
      lead = 0; rises = 0; mon_word = '0; in_lead = 1;
      miso_i = slv_word[W-1];
      slv_sr = slv_word << 1;
    end
    if (!ss_no && !sclk_o && in_lead) lead++;
    if (sclk_o && !prev_sclk) begin
      in_lead = 0;
      rises++;
      if (rises > 1) begin
        miso_i = slv_sr[W-1];
        slv_sr = slv_sr << 1;
      end
    end
    if (!sclk_o && prev_sclk) mon_word = {mon_word[W-2:0], mosi_o};
    prev_ss   = ss_no;
    prev_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_on_tick(input logic [W-1:0] tx);
    @(negedge clk_i);
    while (!tick_i) @(negedge clk_i);
    start_i = 1'b1; tx_word_i = tx;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 5000; i++) begin
      if (rx_valid_o) break;
      @(negedge clk_i);
    end
    #1;
  endtask

  task automatic t_reset();
    chk(ready_o === 1'b1, "R1 ready", 32'(ready_o), 1);
    chk(ss_no === 1'b1 && sclk_o === 1'b0, "R1 ss/sclk", {ss_no, sclk_o}, 2);
    chk(mosi_oe_o === 1'b0 && rx_valid_o === 1'b0, "R1 oe/valid",
        {mosi_oe_o, rx_valid_o}, 0);
  endtask

  task automatic t_idle();
    idle_edges = 0;
    repeat (40) @(negedge clk_i);
    #1;
    chk(idle_edges == 0 && sclk_o == 1'b0, "R1 idle ticks", idle_edges, 0);
  endtask

  task automatic t_word(input logic [W-1:0] tx, input logic [W-1:0] slv);
    slv_word = slv;
    start_on_tick(tx);
    wait_valid();
    chk(rx_valid_o === 1'b1, "R7 valid seen", 32'(rx_valid_o), 1);
    chk(lead == tick_div, "R2 lead", lead, tick_div);
    chk(rises == W, "R3 rises", rises, W);
    chk(mon_word == tx, "R4 mosi word", mon_word, tx);
    chk(rx_word_o == slv, "R5 rx word", rx_word_o, slv);
    chk(ss_no === 1'b1 && mosi_oe_o === 1'b0, "R6 release", {ss_no, mosi_oe_o}, 2);
    @(negedge clk_i); #1;
    chk(rx_valid_o === 1'b0, "R7 pulse width", 32'(rx_valid_o), 0);
  endtask

  task automatic t_busy_start(input logic [W-1:0] a, input logic [W-1:0] b);
    slv_word = ~a;
    start_on_tick(a);
    repeat (5) @(negedge clk_i);
    start_i = 1'b1; tx_word_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_valid();
    chk(mon_word == a, "R8 word unchanged", mon_word, a);
    repeat (40) @(negedge clk_i); #1;
    chk(ss_no === 1'b1 && ready_o === 1'b1, "R8 no extra word", {ss_no, ready_o}, 3);
  endtask

  task automatic t_b2b(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] sa, input logic [W-1:0] sb);
    slv_word = sa;
    start_on_tick(a);
    wait_valid();
    chk(ready_o === 1'b1, "R9 ready at valid", 32'(ready_o), 1);
    slv_word = sb;
    start_i = 1'b1; tx_word_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    chk(ss_no === 1'b0, "R9 immediate start", 32'(ss_no), 0);
    repeat (6) @(negedge clk_i); #1;
    chk(rx_word_o == sa, "R7 rx held", rx_word_o, sa);
    wait_valid();
    chk(mon_word == b, "R9 second mosi", mon_word, b);
    chk(rx_word_o == sb, "R9 second rx", rx_word_o, sb);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    t_reset();
    t_idle();
    tick_div = 3;
    t_word(8'hA5, 8'h3C);
    t_word(8'h00, 8'hFF);
    tick_div = 1;
    t_word(8'hFF, 8'h00);
    t_word(8'h80, 8'h01);
    tick_div = 5;
    t_word(8'h01, 8'h80);
    t_idle();
    tick_div = 2;
    t_busy_start(8'h5A, 8'hC3);
    t_b2b(8'h96, 8'h69, 8'hE1, 8'h1E);
    tick_div = 1;
    t_b2b(8'hF0, 8'h0F, 8'h55, 8'hAA);
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule